// File: doc/BRIEF.md
# Fast-Control Link Word Formatter and Decoder

This block builds the 16-bit word that a fast-control serial link carries toward the front-end crates on every 53 MHz clock. Three timing flags — the bunch-crossing sync mark, the level-1 accept and the pipeline-advance mark — appear in the first word after the clock in which they occur. They are never held back. Each word can also carry one payload, chosen by a 2-bit header in the top bits: a 5-bit command, an 8-bit bunch number or a 5-bit pipeline capacitor number.

The formatter decides which payload goes out in each word. A command request always goes out at once. Bunch-number and capacitor-number requests wait in one-entry slots until their turn comes. A capacitor number may only follow a readout command that was itself preceded by an accept.

The matching decoder sits at the receiving end. It takes a 16-bit word and returns the flags, the bunch and capacitor payloads with their valid marks, and a one-clock strobe for each command code the front end acts on.

Top module: `ctl_link_fmt`

## Requirements
- R1: `word_o` is registered. Every word with a non-zero header carries the previous clock's `sync_i`, `accept_i` and `advance_i` in bits 13, 12 and 11, whatever the payload is.
- R2: Bits 15:14 encode the word type: 11 command, 10 bunch number, 01 capacitor number, 00 no-op. The command sits in bits 10:6, the bunch number in bits 10:3 and the capacitor number in bits 10:6. All unused bits are zero, and a no-op word is entirely zero.
- R3: Payload priority is command, then capacitor number, then bunch number. A command request (`cmd_req_i`) always produces a command word on the next clock.
- R4: A bunch or capacitor request that cannot go out at once is held until it is sent. A second request of the same kind that arrives while one is held is dropped.
- R5: A capacitor word is sent only once it is armed. Arming happens when a readout command (code 0x05) is sent in or after a clock that had `accept_i` high. Each arming allows exactly one capacitor word.
- R6: If no payload can be sent and any flag is high, the word is a bunch-number word carrying the live `bunch_num_i`. If there is no payload and no flag, the word is a no-op.
- R7: The decoder registers its outputs one clock after `rx_word_i`. A word with header 00 yields all-zero outputs, whatever its other bits hold.
- R8: A command word raises exactly one bit of `rx_cmd_stb_o` for one clock, and only for a valid code. The index order is 0:0x02, 1:0x03, 2:0x04, 3:0x05, 4:0x08, 5:0x09, 6:0x11, 7:0x12, 8:0x13, 9:0x14, 10:0x15. Every other code gives no strobe.
- R9: In a command or capacitor word with bits 5:0 non-zero, or a bunch word with bits 2:0 non-zero, the payload is ignored (no strobe, no valid). The flags are still recovered.
- R10: Reset clears `word_o`, all decoder outputs, both held requests, the seen-accept state and the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 53 MHz word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Bunch-crossing sync mark for this clock |
| accept_i | input | 1 | Level-1 accept for this clock |
| advance_i | input | 1 | Pipeline-advance mark for this clock |
| cmd_req_i | input | 1 | Send `cmd_code_i` in the next word |
| cmd_code_i | input | 5 | Command code |
| bunch_req_i | input | 1 | Request to send `bunch_num_i` |
| bunch_num_i | input | 8 | Bunch number (captured on request, also used live for flag-only words) |
| cap_req_i | input | 1 | Request to send `cap_num_i` |
| cap_num_i | input | 5 | Pipeline capacitor number |
| word_o | output | 16 | Formatted link word |
| rx_word_i | input | 16 | Received link word for the decoder |
| rx_sync_o | output | 1 | Recovered sync flag |
| rx_accept_o | output | 1 | Recovered accept flag |
| rx_advance_o | output | 1 | Recovered advance flag |
| rx_cmd_stb_o | output | 11 | One-clock strobe per valid command code |
| rx_bunch_vld_o | output | 1 | Bunch payload valid |
| rx_bunch_o | output | 8 | Recovered bunch number |
| rx_cap_vld_o | output | 1 | Capacitor payload valid |
| rx_cap_o | output | 5 | Recovered capacitor number |

## Verification
The properties treat every input as a per-clock level: a request that is high in two clocks counts as two requests. The decoder may be fed any 16-bit pattern, including malformed ones. The stimulus therefore raises each request for exactly one clock unless a back-to-back sequence is being tested, and it changes inputs only on the falling edge. The decoder table deliberately includes no-op words with stray bits, unlisted command codes and words with non-zero reserved bits, so that the exclusivity and no-op properties see more than well-formed traffic.

// File: rtl/ctl_link_pkg.sv
package ctl_link_pkg;
    localparam int WORD_W   = 16;
    localparam int CMD_W    = 5;
    localparam int BUNCH_W  = 8;
    localparam int CAP_W    = 5;
    localparam int NCMD     = 11;
    localparam int TYPE_LSB = WORD_W - 2;
    localparam int SYNC_BIT = TYPE_LSB - 1;
    localparam int ACC_BIT  = TYPE_LSB - 2;
    localparam int ADV_BIT  = TYPE_LSB - 3;
    localparam int PAY_MSB  = ADV_BIT - 1;
    localparam int CMD_PAD   = PAY_MSB + 1 - CMD_W;
    localparam int BUNCH_PAD = PAY_MSB + 1 - BUNCH_W;
    localparam int CAP_PAD   = PAY_MSB + 1 - CAP_W;
    localparam logic [CMD_W-1:0] READOUT_CODE = 5'h05;

    typedef enum logic [1:0] {
        HDR_NOP   = 2'b00,
        HDR_CAP   = 2'b01,
        HDR_BUNCH = 2'b10,
        HDR_CMD   = 2'b11
    } hdr_e;

    function automatic logic [CMD_W-1:0] cmd_code_at(input int unsigned idx);
        case (idx)
            0:  return 5'h02;
            1:  return 5'h03;
            2:  return 5'h04;
            3:  return 5'h05;
            4:  return 5'h08;
            5:  return 5'h09;
            6:  return 5'h11;
            7:  return 5'h12;
            8:  return 5'h13;
            9:  return 5'h14;
            default: return 5'h15;
        endcase
    endfunction
endpackage

// File: rtl/ctl_link_tx.sv
module ctl_link_tx
    import ctl_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic               accept_i,
    input  logic               advance_i,
    input  logic               cmd_req_i,
    input  logic [CMD_W-1:0]   cmd_code_i,
    input  logic               bunch_req_i,
    input  logic [BUNCH_W-1:0] bunch_num_i,
    input  logic               cap_req_i,
    input  logic [CAP_W-1:0]   cap_num_i,
    output logic [WORD_W-1:0]  word_o
);
    typedef struct packed {
        logic [WORD_W-1:0]  word;
        logic               acc_seen;
        logic               cap_arm;
        logic               bunch_pend;
        logic [BUNCH_W-1:0] bunch_val;
        logic               cap_pend;
        logic [CAP_W-1:0]   cap_val;
    } tx_st_t;

    tx_st_t st_q, st_d;

    always_comb begin
        logic [2:0]         flags;
        logic               have_bunch;
        logic               have_cap;
        logic [BUNCH_W-1:0] bval;
        logic [CAP_W-1:0]   cval;
        logic               sent_b;
        logic               sent_c;
        logic               readout_sent;

        st_d       = st_q;
        flags      = {sync_i, accept_i, advance_i};
        have_bunch = st_q.bunch_pend | bunch_req_i;
        have_cap   = st_q.cap_pend | cap_req_i;
        bval       = st_q.bunch_pend ? st_q.bunch_val : bunch_num_i;
        cval       = st_q.cap_pend ? st_q.cap_val : cap_num_i;
        sent_b     = 1'b0;
        sent_c     = 1'b0;

        st_d.word = '0;
        st_d.word[SYNC_BIT:ADV_BIT] = flags;
        if (cmd_req_i) begin
            st_d.word[WORD_W-1:TYPE_LSB] = HDR_CMD;
            st_d.word[PAY_MSB -: CMD_W]  = cmd_code_i;
        end else if (have_cap && st_q.cap_arm) begin
            st_d.word[WORD_W-1:TYPE_LSB] = HDR_CAP;
            st_d.word[PAY_MSB -: CAP_W]  = cval;
            sent_c = 1'b1;
        end else if (have_bunch) begin
            st_d.word[WORD_W-1:TYPE_LSB] = HDR_BUNCH;
            st_d.word[PAY_MSB -: BUNCH_W] = bval;
            sent_b = 1'b1;
        end else if (|flags) begin
            st_d.word[WORD_W-1:TYPE_LSB] = HDR_BUNCH;
            st_d.word[PAY_MSB -: BUNCH_W] = bunch_num_i;
        end

        readout_sent = cmd_req_i && (cmd_code_i == READOUT_CODE);

        st_d.bunch_pend = have_bunch & ~sent_b;
        st_d.bunch_val  = have_bunch ? bval : st_q.bunch_val;
        st_d.cap_pend   = have_cap & ~sent_c;
        st_d.cap_val    = have_cap ? cval : st_q.cap_val;

        if (readout_sent && (st_q.acc_seen || accept_i)) begin
            st_d.cap_arm = 1'b1;
        end else if (sent_c) begin
            st_d.cap_arm = 1'b0;
        end
        st_d.acc_seen = readout_sent ? 1'b0 : (st_q.acc_seen | accept_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
endmodule

// File: rtl/ctl_link_rx.sv
module ctl_link_rx
    import ctl_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  rx_word_i,
    output logic               rx_sync_o,
    output logic               rx_accept_o,
    output logic               rx_advance_o,
    output logic [NCMD-1:0]    rx_cmd_stb_o,
    output logic               rx_bunch_vld_o,
    output logic [BUNCH_W-1:0] rx_bunch_o,
    output logic               rx_cap_vld_o,
    output logic [CAP_W-1:0]   rx_cap_o
);
    typedef struct packed {
        logic               sync;
        logic               acc;
        logic               adv;
        logic [NCMD-1:0]    stb;
        logic               bv;
        logic [BUNCH_W-1:0] bunch;
        logic               cv;
        logic [CAP_W-1:0]   cap;
    } rx_st_t;

    rx_st_t          st_q, st_d;
    logic [NCMD-1:0] cmd_hit;

    for (genvar i = 0; i < NCMD; i++) begin : g_hit
        assign cmd_hit[i] = (rx_word_i[PAY_MSB -: CMD_W] == cmd_code_at(i));
    end

    always_comb begin
        hdr_e hdr;
        hdr  = hdr_e'(rx_word_i[WORD_W-1:TYPE_LSB]);
        st_d = '0;
        if (hdr != HDR_NOP) begin
            st_d.sync = rx_word_i[SYNC_BIT];
            st_d.acc  = rx_word_i[ACC_BIT];
            st_d.adv  = rx_word_i[ADV_BIT];
        end
        case (hdr)
            HDR_CMD: begin
                if (rx_word_i[CMD_PAD-1:0] == '0) st_d.stb = cmd_hit;
            end
            HDR_BUNCH: begin
                if (rx_word_i[BUNCH_PAD-1:0] == '0) begin
                    st_d.bv    = 1'b1;
                    st_d.bunch = rx_word_i[PAY_MSB -: BUNCH_W];
                end
            end
            HDR_CAP: begin
                if (rx_word_i[CAP_PAD-1:0] == '0) begin
                    st_d.cv  = 1'b1;
                    st_d.cap = rx_word_i[PAY_MSB -: CAP_W];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_sync_o      = st_q.sync;
    assign rx_accept_o    = st_q.acc;
    assign rx_advance_o   = st_q.adv;
    assign rx_cmd_stb_o   = st_q.stb;
    assign rx_bunch_vld_o = st_q.bv;
    assign rx_bunch_o     = st_q.bunch;
    assign rx_cap_vld_o   = st_q.cv;
    assign rx_cap_o       = st_q.cap;
endmodule

// File: rtl/ctl_link_fmt.sv
module ctl_link_fmt
    import ctl_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic               accept_i,
    input  logic               advance_i,
    input  logic               cmd_req_i,
    input  logic [CMD_W-1:0]   cmd_code_i,
    input  logic               bunch_req_i,
    input  logic [BUNCH_W-1:0] bunch_num_i,
    input  logic               cap_req_i,
    input  logic [CAP_W-1:0]   cap_num_i,
    output logic [WORD_W-1:0]  word_o,
    input  logic [WORD_W-1:0]  rx_word_i,
    output logic               rx_sync_o,
    output logic               rx_accept_o,
    output logic               rx_advance_o,
    output logic [NCMD-1:0]    rx_cmd_stb_o,
    output logic               rx_bunch_vld_o,
    output logic [BUNCH_W-1:0] rx_bunch_o,
    output logic               rx_cap_vld_o,
    output logic [CAP_W-1:0]   rx_cap_o
);
    ctl_link_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .accept_i    (accept_i),
        .advance_i   (advance_i),
        .cmd_req_i   (cmd_req_i),
        .cmd_code_i  (cmd_code_i),
        .bunch_req_i (bunch_req_i),
        .bunch_num_i (bunch_num_i),
        .cap_req_i   (cap_req_i),
        .cap_num_i   (cap_num_i),
        .word_o      (word_o)
    );

    ctl_link_rx u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_word_i      (rx_word_i),
        .rx_sync_o      (rx_sync_o),
        .rx_accept_o    (rx_accept_o),
        .rx_advance_o   (rx_advance_o),
        .rx_cmd_stb_o   (rx_cmd_stb_o),
        .rx_bunch_vld_o (rx_bunch_vld_o),
        .rx_bunch_o     (rx_bunch_o),
        .rx_cap_vld_o   (rx_cap_vld_o),
        .rx_cap_o       (rx_cap_o)
    );
endmodule

// File: rtl/ctl_link_fmt_chk.sv
module ctl_link_fmt_chk
    import ctl_link_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic              accept_i,
    input logic              advance_i,
    input logic              cmd_req_i,
    input logic [WORD_W-1:0] word_o,
    input logic [WORD_W-1:0] rx_word_i,
    input logic              rx_sync_o,
    input logic              rx_accept_o,
    input logic              rx_advance_o,
    input logic [NCMD-1:0]   rx_cmd_stb_o,
    input logic              rx_bunch_vld_o,
    input logic              rx_cap_vld_o
);
    // R1: flags of a clock appear in the next word
    assert_flags_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i || accept_i || advance_i) |=>
            (word_o[SYNC_BIT:ADV_BIT] == $past({sync_i, accept_i, advance_i})));

    assert_noop_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o[WORD_W-1:TYPE_LSB] == 2'b00) |-> (word_o == '0));

    assert_cmd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_i |=> (word_o[WORD_W-1:TYPE_LSB] == 2'b11));

    assert_cap_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o[WORD_W-1:TYPE_LSB] == 2'b01) |=> (word_o[WORD_W-1:TYPE_LSB] != 2'b01));

    assert_flag_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i || accept_i || advance_i) |=> (word_o[WORD_W-1:TYPE_LSB] != 2'b00));

    assert_rx_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_i[WORD_W-1:TYPE_LSB] == 2'b00) |=>
            (!rx_sync_o && !rx_accept_o && !rx_advance_o && (rx_cmd_stb_o == '0)
             && !rx_bunch_vld_o && !rx_cap_vld_o));

    assert_rx_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({|rx_cmd_stb_o, rx_bunch_vld_o, rx_cap_vld_o}) <= 1);

    assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_cmd_stb_o));
endmodule

bind ctl_link_fmt ctl_link_fmt_chk u_chk (.*);

// File: tb/ctl_link_fmt_tb.sv
module ctl_link_fmt_tb;
    localparam time CLK_P = 4ns;
    localparam int  NVEC  = 13;

    // word, flags{sync,acc,adv}, kind(0 none,1 cmd,2 bunch,3 cap), strobe index, payload
    localparam logic [32:0] VEC [NVEC] = '{
        {16'hE140, 3'b100, 2'd1, 4'd3,  8'h05},
        {16'hC540, 3'b000, 2'd1, 4'd10, 8'h15},
        {16'hD1C0, 3'b010, 2'd0, 4'd0,  8'h00},
        {16'hC880, 3'b001, 2'd1, 4'd0,  8'h02},
        {16'hB528, 3'b110, 2'd2, 4'd0,  8'hA5},
        {16'h8000, 3'b000, 2'd2, 4'd0,  8'h00},
        {16'h4F40, 3'b001, 2'd3, 4'd0,  8'h1D},
        {16'h0000, 3'b000, 2'd0, 4'd0,  8'h00},
        {16'h3FFF, 3'b000, 2'd0, 4'd0,  8'h00},
        {16'hFC80, 3'b111, 2'd1, 4'd7,  8'h12},
        {16'hC280, 3'b000, 2'd0, 4'd0,  8'h00},
        {16'hC440, 3'b000, 2'd1, 4'd6,  8'h11},
        {16'hC141, 3'b000, 2'd0, 4'd0,  8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0, accept_i = 1'b0, advance_i = 1'b0;
    logic        cmd_req_i = 1'b0;
    logic [4:0]  cmd_code_i = '0;
    logic        bunch_req_i = 1'b0;
    logic [7:0]  bunch_num_i = 8'h3C;
    logic        cap_req_i = 1'b0;
    logic [4:0]  cap_num_i = '0;
    logic [15:0] word_o;
    logic [15:0] rx_tb = '0;
    logic        loopback = 1'b0;
    logic [15:0] rx_word;
    logic        rx_sync_o, rx_accept_o, rx_advance_o;
    logic [10:0] rx_cmd_stb_o;
    logic        rx_bunch_vld_o, rx_cap_vld_o;
    logic [7:0]  rx_bunch_o;
    logic [4:0]  rx_cap_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    assign rx_word = loopback ? word_o : rx_tb;

    always #(CLK_P/2) clk = ~clk;

    ctl_link_fmt u_dut (
        .clk(clk), .rst_n(rst_n),
        .sync_i(sync_i), .accept_i(accept_i), .advance_i(advance_i),
        .cmd_req_i(cmd_req_i), .cmd_code_i(cmd_code_i),
        .bunch_req_i(bunch_req_i), .bunch_num_i(bunch_num_i),
        .cap_req_i(cap_req_i), .cap_num_i(cap_num_i),
        .word_o(word_o), .rx_word_i(rx_word),
        .rx_sync_o(rx_sync_o), .rx_accept_o(rx_accept_o), .rx_advance_o(rx_advance_o),
        .rx_cmd_stb_o(rx_cmd_stb_o), .rx_bunch_vld_o(rx_bunch_vld_o),
        .rx_bunch_o(rx_bunch_o), .rx_cap_vld_o(rx_cap_vld_o), .rx_cap_o(rx_cap_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        sync_i = 0; accept_i = 0; advance_i = 0;
        cmd_req_i = 0; bunch_req_i = 0; cap_req_i = 0;
        bunch_num_i = 8'h3C;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 word in reset", 32'(word_o), 32'h0);
        chk("R10 rx in reset", 32'({rx_sync_o, rx_accept_o, rx_advance_o, rx_cmd_stb_o,
                                    rx_bunch_vld_o, rx_cap_vld_o}), 32'h0);
        rst_n = 1'b1;
        tick();

        // decoder table, R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] w;
            logic [2:0]  fl;
            logic [1:0]  kind;
            logic [3:0]  idx;
            logic [7:0]  val;
            {w, fl, kind, idx, val} = VEC[i];
            rx_tb = w;
            tick();
            chk("R7 flags", 32'({rx_sync_o, rx_accept_o, rx_advance_o}), 32'(fl));
            chk("R8 strobe", 32'(rx_cmd_stb_o), (kind == 2'd1) ? (32'd1 << idx) : 32'd0);
            chk("R9 bunch valid", 32'(rx_bunch_vld_o), 32'(kind == 2'd2));
            chk("R9 cap valid", 32'(rx_cap_vld_o), 32'(kind == 2'd3));
            if (kind == 2'd2) chk("R7 bunch value", 32'(rx_bunch_o), 32'(val));
            if (kind == 2'd3) chk("R7 cap value", 32'(rx_cap_o), 32'(val));
        end
        rx_tb = '0;

        // R6 idle gives no-op
        idle_in(); tick();
        chk("R6 noop", 32'(word_o), 32'h0);
        // R6 R1 flag-only word uses live bunch
        sync_i = 1; advance_i = 1; tick();
        chk("R6 flag bunch word", 32'(word_o), 32'hA9E0);
        // R3 R1 command with accept
        idle_in(); cmd_req_i = 1; cmd_code_i = 5'h03; accept_i = 1; tick();
        chk("R3 cmd word", 32'(word_o), 32'hD0C0);
        // R3 R4 collision
        idle_in(); cmd_req_i = 1; cmd_code_i = 5'h04;
        bunch_req_i = 1; bunch_num_i = 8'h11; cap_req_i = 1; cap_num_i = 5'd29; tick();
        chk("R3 cmd wins", 32'(word_o), 32'hC100);
        idle_in(); tick();
        chk("R4 held bunch", 32'(word_o), 32'h8088);
        tick();
        chk("R5 cap held unarmed", 32'(word_o), 32'h0);
        cmd_req_i = 1; cmd_code_i = 5'h05; bunch_req_i = 1; bunch_num_i = 8'h22; tick();
        chk("R5 readout word", 32'(word_o), 32'hC140);
        idle_in(); tick();
        chk("R3 cap over bunch", 32'(word_o), 32'h4740);
        tick();
        chk("R4 bunch after cap", 32'(word_o), 32'h8110);
        tick();
        chk("R5 idle after", 32'(word_o), 32'h0);
        // R4 drop second bunch
        cmd_req_i = 1; cmd_code_i = 5'h09; bunch_req_i = 1; bunch_num_i = 8'h11; tick();
        chk("R3 cmd 09", 32'(word_o), 32'hC240);
        cmd_req_i = 1; cmd_code_i = 5'h02; bunch_req_i = 1; bunch_num_i = 8'h22; tick();
        chk("R3 cmd 02", 32'(word_o), 32'hC080);
        idle_in(); tick();
        chk("R4 oldest kept", 32'(word_o), 32'h8088);
        tick();
        chk("R4 second dropped", 32'(word_o), 32'h0);

        // R10 reset mid-run then R5 gating
        rst_n = 0; @(negedge clk);
        chk("R10 word cleared", 32'(word_o), 32'h0);
        rst_n = 1; tick();
        cap_req_i = 1; cap_num_i = 5'd7; cmd_req_i = 1; cmd_code_i = 5'h05; tick();
        chk("R5 readout no accept", 32'(word_o), 32'hC140);
        idle_in(); tick();
        chk("R5 not armed", 32'(word_o), 32'h0);
        accept_i = 1; tick();
        chk("R6 accept only", 32'(word_o), 32'h91E0);
        idle_in(); cmd_req_i = 1; cmd_code_i = 5'h05; tick();
        chk("R5 readout after accept", 32'(word_o), 32'hC140);
        idle_in(); tick();
        chk("R5 cap sent", 32'(word_o), 32'h41C0);
        tick();
        chk("R5 one per arming", 32'(word_o), 32'h0);

        // loopback R2 R8
        loopback = 1; cmd_req_i = 1; cmd_code_i = 5'h13; tick();
        chk("R2 cmd 13 word", 32'(word_o), 32'hC4C0);
        idle_in(); tick();
        chk("R8 loop strobe", 32'(rx_cmd_stb_o), 32'h100);
        tick();
        chk("R8 strobe one clock", 32'(rx_cmd_stb_o), 32'h0);

        finish_run();
    end
endmodule